// File: doc/BRIEF.md
# I2C Byte Master with Command Register

This block is a single-master I2C controller that software steers one bus condition at a time. A divider register sets the length of every SCL half-period. A transfer register takes one command per write: a start (or repeated start), a stop, a byte write, or a byte read with an optional acknowledge. The same register reports whether the sequencer is idle, the acknowledge seen in the last ninth clock, and the last byte shifted in.

Software writes a command, polls the idle flag until it reads set, then issues the next command. Both bus lines are open-drain. The output value is tied to 0. A line is pulled low by asserting its output enable and released by clearing it. SDA is read back through its input pin. SCL is only driven, so the device cannot stretch the clock.

Top module: `i2c_byte_master`

## Requirements
- R1: During reset and after it, both output enables are 0 (lines released), the idle flag (transfer register bit 13) reads 1, and the divider reads 0.
- R2: A write to the divider register (select 0) stores data bits 7:0, which read back in bits 7:0. A divider write while a command is running is ignored.
- R3: Every bus phase lasts exactly divider+1 clock cycles. A start issued on a free bus clears the idle flag right after the accepting edge, and the flag reads set again divider+1 cycles later.
- R4: A start command (bit 8) on a free bus pulls SDA low while SCL stays released. The sequencer then idles with SCL high and SDA low.
- R5: A write command (bit 10, byte in bits 7:0) sends the byte MSB first. Each bit is one SCL-low phase followed by one SCL-high phase, with SDA set as SCL falls and held through the high phase.
- R6: On the ninth clock of a write, SDA is released and sampled at the end of the SCL-high phase. Bit 12 of the transfer register then reads 1 if SDA was low and 0 if it was high. Bits 7:0 read back the byte as seen on the bus.
- R7: A read command (bit 11) releases SDA for eight clocks and samples it at the end of each SCL-high phase, MSB first. The byte reads back in bits 7:0.
- R8: On the ninth clock of a read, SDA is pulled low if command bit 12 was set, and released otherwise. Status bit 12 then reads 1 or 0 to match.
- R9: A stop command (bit 9) runs three phases: SCL low with SDA low, then SCL high with SDA low, then both released. The bus is then free.
- R10: A start command (bit 8, alone or with bit 9) while the bus is held runs three phases: SCL low with SDA released, then SCL high, then SDA low with SCL high.
- R11: While a command runs, the idle flag reads 0 and any further transfer-register write is ignored. The lines do not move while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 divider, 1 transfer |
| reg_wdata | input | 13 | Write data: bits 7:0 byte or divider, bits 12:8 command flags |
| reg_rdata | output | 14 | Read data of the selected register |
| scl_o | output | 1 | SCL output value (always 0) |
| scl_oe | output | 1 | SCL output enable, 1 pulls SCL low |
| sda_o | output | 1 | SDA output value (always 0) |
| sda_oe | output | 1 | SDA output enable, 1 pulls SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
A command is accepted on the clock edge where the write strobe is seen. Its first phase shows on the lines right after that edge, and each later phase begins divider+1 edges after the one before. The idle flag returns after 1, 3 or 18 phases for a start, a stop or repeated start, or a byte. The bench drives inputs and samples outputs on the falling clock edge. It steps through each phase by waiting exactly divider+1 falling edges, so every sample lands inside the phase it checks. The acknowledge and data results are read only once the expected number of phases has elapsed. Two divider values are used so that a wrong phase length shifts every later sample.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned B_START = 8;
  localparam int unsigned B_STOP  = 9;
  localparam int unsigned B_WRITE = 10;
  localparam int unsigned B_READ  = 11;
  localparam int unsigned B_ACK   = 12;
  localparam int unsigned B_IDLE  = 13;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_RS_LOW,
    SQ_RS_HIGH,
    SQ_START,
    SQ_SP_LOW,
    SQ_SP_HIGH,
    SQ_SP_RISE,
    SQ_BIT_LOW,
    SQ_BIT_HIGH
  } sq_state_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic wr;
    logic rd;
    logic ack;
  } cmd_t;

endpackage

// File: rtl/i2cm_halfper.sv
module i2cm_halfper #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: phase counter never passes the divider while running
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div));

  // R3: each phase restarts its count after a tick
  p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              tick,
  input  logic              sda_in,
  output logic              busy,
  output logic              scl_line,
  output logic              sda_line,
  output logic [DATA_W-1:0] rx_data,
  output logic              ack_rx
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  sq_state_t         state_q, state_d;
  logic [CNT_W-1:0]  bitn_q, bitn_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              wr_q, wr_d;
  logic              ackopt_q, ackopt_d;
  logic              active_q, active_d;
  logic              ackrx_q, ackrx_d;
  logic              hscl_q, hsda_q;
  logic              out_bit;

  assign busy    = (state_q != SQ_IDLE);
  assign rx_data = shreg_q;
  assign ack_rx  = ackrx_q;

  // value presented on SDA during a bit slot
  always_comb begin
    if (bitn_q == LAST_BIT) out_bit = wr_q ? 1'b1 : ~ackopt_q;
    else                    out_bit = wr_q ? shreg_q[DATA_W-1] : 1'b1;
  end

  // line levels per state, 1 = released
  always_comb begin
    scl_line = hscl_q;
    sda_line = hsda_q;
    unique case (state_q)
      SQ_RS_LOW:   begin scl_line = 1'b0; sda_line = 1'b1; end
      SQ_RS_HIGH:  begin scl_line = 1'b1; sda_line = 1'b1; end
      SQ_START:    begin scl_line = 1'b1; sda_line = 1'b0; end
      SQ_SP_LOW:   begin scl_line = 1'b0; sda_line = 1'b0; end
      SQ_SP_HIGH:  begin scl_line = 1'b1; sda_line = 1'b0; end
      SQ_SP_RISE:  begin scl_line = 1'b1; sda_line = 1'b1; end
      SQ_BIT_LOW:  begin scl_line = 1'b0; sda_line = out_bit; end
      SQ_BIT_HIGH: begin scl_line = 1'b1; sda_line = out_bit; end
      default:     begin scl_line = hscl_q; sda_line = hsda_q; end
    endcase
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    bitn_d   = bitn_q;
    shreg_d  = shreg_q;
    wr_d     = wr_q;
    ackopt_d = ackopt_q;
    active_d = active_q;
    ackrx_d  = ackrx_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (cmd_we) begin
          if (cmd.start) begin
            state_d = active_q ? SQ_RS_LOW : SQ_START;
          end else if (cmd.stop) begin
            state_d = SQ_SP_LOW;
          end else if (cmd.wr) begin
            state_d = SQ_BIT_LOW;
            wr_d    = 1'b1;
            shreg_d = cmd_data;
            bitn_d  = '0;
          end else if (cmd.rd) begin
            state_d  = SQ_BIT_LOW;
            wr_d     = 1'b0;
            ackopt_d = cmd.ack;
            bitn_d   = '0;
          end
        end
      end
      SQ_RS_LOW:  if (tick) state_d = SQ_RS_HIGH;
      SQ_RS_HIGH: if (tick) state_d = SQ_START;
      SQ_START: if (tick) begin
        state_d  = SQ_IDLE;
        active_d = 1'b1;
      end
      SQ_SP_LOW:  if (tick) state_d = SQ_SP_HIGH;
      SQ_SP_HIGH: if (tick) state_d = SQ_SP_RISE;
      SQ_SP_RISE: if (tick) begin
        state_d  = SQ_IDLE;
        active_d = 1'b0;
      end
      SQ_BIT_LOW: if (tick) state_d = SQ_BIT_HIGH;
      SQ_BIT_HIGH: if (tick) begin
        if (bitn_q == LAST_BIT) begin
          ackrx_d = ~sda_in;
          state_d = SQ_IDLE;
        end else begin
          shreg_d = {shreg_q[DATA_W-2:0], sda_in};
          bitn_d  = bitn_q + 1'b1;
          state_d = SQ_BIT_LOW;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      bitn_q   <= '0;
      shreg_q  <= '0;
      wr_q     <= 1'b0;
      ackopt_q <= 1'b0;
      active_q <= 1'b0;
      ackrx_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitn_q   <= bitn_d;
      shreg_q  <= shreg_d;
      wr_q     <= wr_d;
      ackopt_q <= ackopt_d;
      active_q <= active_d;
      ackrx_q  <= ackrx_d;
    end
  end

  // line levels held while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hscl_q <= 1'b1;
      hsda_q <= 1'b1;
    end else if (busy) begin
      hscl_q <= scl_line;
      hsda_q <= sda_line;
    end
  end

  // R5: SDA does not move during an SCL-high bit phase
  p_sda_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_BIT_HIGH && $past(state_q) == SQ_BIT_HIGH) |-> $stable(sda_line));

  // R11: a running command only advances on a phase tick
  p_no_early_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(state_q));

  // R11: lines stay put while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && $past(state_q) == SQ_IDLE) |-> ($stable(scl_line) && $stable(sda_line)));

  // R9: the bus is free once a stop completes
  p_stop_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SP_RISE && tick) |=> (state_q == SQ_IDLE && scl_line && sda_line));

  // R4: a start leaves SCL high and SDA low when it completes
  p_start_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_START && tick) |=> (scl_line && !sda_line));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [12:0] reg_wdata,
  output logic [13:0] reg_rdata,
  output logic        scl_o,
  output logic        scl_oe,
  output logic        sda_o,
  output logic        sda_oe,
  input  logic        sda_i
);

  localparam int unsigned RD_W  = B_IDLE + 1;
  localparam int unsigned PAD_W = RD_W - DIV_W;

  logic [1:0]       rsync_q;
  logic             rst_ns;
  logic [DIV_W-1:0] div_q;
  logic             cfg_we, cmd_we, busy, tick;
  logic             scl_line, sda_line, ack_rx;
  logic [BYTE_W-1:0] rx_data;
  cmd_t             cmd;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  assign cfg_we = reg_we && !reg_sel && !busy;
  assign cmd_we = reg_we &&  reg_sel && !busy;

  assign cmd.start = reg_wdata[B_START];
  assign cmd.stop  = reg_wdata[B_STOP];
  assign cmd.wr    = reg_wdata[B_WRITE];
  assign cmd.rd    = reg_wdata[B_READ];
  assign cmd.ack   = reg_wdata[B_ACK];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     div_q <= '0;
    else if (cfg_we) div_q <= reg_wdata[DIV_W-1:0];
  end

  i2cm_halfper #(.DIV_W(DIV_W)) i_halfper (
    .clk  (clk),
    .rst_n(rst_ns),
    .run  (busy),
    .div  (div_q),
    .tick (tick)
  );

  i2cm_seq #(.DATA_W(BYTE_W)) i_seq (
    .clk     (clk),
    .rst_n   (rst_ns),
    .cmd_we  (cmd_we),
    .cmd     (cmd),
    .cmd_data(reg_wdata[BYTE_W-1:0]),
    .tick    (tick),
    .sda_in  (sda_i),
    .busy    (busy),
    .scl_line(scl_line),
    .sda_line(sda_line),
    .rx_data (rx_data),
    .ack_rx  (ack_rx)
  );

  always_comb begin
    if (reg_sel) reg_rdata = {~busy, ack_rx, 4'b0000, rx_data};
    else         reg_rdata = {{PAD_W{1'b0}}, div_q};
  end

  assign scl_o  = 1'b0;
  assign sda_o  = 1'b0;
  assign scl_oe = ~scl_line;
  assign sda_oe = ~sda_line;

  // R2: divider is frozen while a command runs
  p_div_frozen_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_we && !reg_sel && busy) |=> $stable(div_q));

endmodule

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic        reg_sel;
  logic [12:0] reg_wdata;
  logic [13:0] reg_rdata;
  logic        scl_o, scl_oe, sda_o, sda_oe;
  logic        slave_sda;
  logic        sda_i;

  int checks = 0;
  int errors = 0;
  int div_b  = 0;

  always #2.5 clk = ~clk;

  assign sda_i = sda_oe ? 1'b0 : slave_sda;

  i2c_byte_master i_i2c_byte_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .scl_o    (scl_o),
    .scl_oe   (scl_oe),
    .sda_o    (sda_o),
    .sda_oe   (sda_oe),
    .sda_i    (sda_i)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [12:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 1'b1; reg_wdata = '0;
  endtask

  function automatic logic idle_now();
    return reg_rdata[13];
  endfunction

  // check one phase: scl_hi expects SCL released, sda_lo expects master pulling SDA
  task automatic phase(input logic scl_hi, input logic sda_lo, input string req);
    chk(scl_oe == !scl_hi, req, scl_oe, !scl_hi);
    chk(sda_oe == sda_lo, req, sda_oe, sda_lo);
    chk(idle_now() == 1'b0, {req, " busy"}, idle_now(), 0);
    repeat (div_b + 1) @(negedge clk);
  endtask

  task automatic test_reset();
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines", {scl_oe, sda_oe}, 0);
    chk(reg_rdata == 14'h2000, "R1 xfer reg", reg_rdata, 14'h2000);
    reg_sel = 1'b0; #1;
    chk(reg_rdata == 14'h0000, "R1 div reg", reg_rdata, 0);
    reg_sel = 1'b1;
  endtask

  task automatic test_config(input int d);
    wr_reg(1'b0, 13'(d));
    reg_sel = 1'b0; #1;
    chk(reg_rdata == 14'(d), "R2 div readback", reg_rdata, d);
    reg_sel = 1'b1; #1;
    div_b = d;
  endtask

  task automatic test_start_free();
    wr_reg(1'b1, 13'h0100);
    chk(scl_oe == 1'b0 && sda_oe == 1'b1, "R4 start cond", {scl_oe, sda_oe}, 1);
    chk(idle_now() == 1'b0, "R3 idle clear", idle_now(), 0);
    repeat (div_b) @(negedge clk);
    chk(idle_now() == 1'b0, "R3 still busy", idle_now(), 0);
    @(negedge clk);
    chk(idle_now() == 1'b1, "R3 idle after div+1", idle_now(), 1);
    chk(scl_oe == 1'b0 && sda_oe == 1'b1, "R4 held", {scl_oe, sda_oe}, 1);
  endtask

  task automatic test_byte(input logic is_wr, input logic [7:0] d, input logic ack_opt,
                           input logic slave_ack, input logic poke, input string req);
    logic [12:0] c;
    logic exp_lo;
    c = is_wr ? {1'b0, 4'b0100, d} : {ack_opt, 4'b1000, 8'h00};
    wr_reg(1'b1, c);
    for (int i = 0; i < 9; i++) begin
      if (i < 8) slave_sda = is_wr ? 1'b1 : d[7-i];
      else       slave_sda = is_wr ? !slave_ack : 1'b1;
      if (i < 8) exp_lo = is_wr ? !d[7-i] : 1'b0;
      else       exp_lo = is_wr ? 1'b0 : ack_opt;
      chk(scl_oe == 1'b1, {req, " scl low"}, scl_oe, 1);
      chk(sda_oe == exp_lo, {req, " sda in low phase"}, sda_oe, exp_lo);
      if (poke && i == 3) begin
        // R11 R2: writes during a command must not disturb it
        wr_reg(1'b0, 13'h0007);
        repeat (div_b - 1) @(negedge clk);
      end else if (poke && i == 5) begin
        wr_reg(1'b1, 13'h0300);
        repeat (div_b - 1) @(negedge clk);
      end else begin
        repeat (div_b + 1) @(negedge clk);
      end
      phase(1'b1, exp_lo, {req, " scl high"});
    end
    slave_sda = 1'b1;
    #1;
    chk(idle_now() == 1'b1, "R11 idle after byte", idle_now(), 1);
    chk(reg_rdata[7:0] == d, {req, " data"}, reg_rdata[7:0], d);
    chk(reg_rdata[12] == (is_wr ? slave_ack : ack_opt), {req, " ack flag"},
        reg_rdata[12], is_wr ? slave_ack : ack_opt);
    if (poke) begin
      reg_sel = 1'b0; #1;
      chk(reg_rdata[7:0] == 8'(div_b), "R2 busy div write ignored", reg_rdata[7:0], div_b);
      reg_sel = 1'b1; #1;
    end
  endtask

  task automatic test_rstart();
    wr_reg(1'b1, 13'h0300);
    phase(1'b0, 1'b0, "R10 scl low sda rel");
    phase(1'b1, 1'b0, "R10 scl high");
    phase(1'b1, 1'b1, "R10 sda falls");
    chk(idle_now() == 1'b1, "R10 idle", idle_now(), 1);
  endtask

  task automatic test_stop();
    wr_reg(1'b1, 13'h0200);
    phase(1'b0, 1'b1, "R9 both low");
    phase(1'b1, 1'b1, "R9 scl high");
    phase(1'b1, 1'b0, "R9 sda rises");
    chk(idle_now() == 1'b1, "R9 idle", idle_now(), 1);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R9 bus free", {scl_oe, sda_oe}, 0);
    repeat (3) @(negedge clk);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R11 idle lines steady", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 1'b1; reg_wdata = '0; slave_sda = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_config(3);
    test_start_free();
    test_byte(1'b1, 8'h82, 1'b0, 1'b1, 1'b1, "R5 R6 write ack");
    test_byte(1'b1, 8'h18, 1'b0, 1'b0, 1'b0, "R5 R6 write nack");
    test_rstart();
    test_byte(1'b0, 8'h18, 1'b0, 1'b0, 1'b0, "R7 R8 read nack");
    test_byte(1'b0, 8'h88, 1'b1, 1'b0, 1'b0, "R7 R8 read ack");
    test_stop();
    test_config(0);
    test_start_free();
    test_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule